// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from one clock domain to another clock domain that runs with no fixed relation to the first. A producer pushes words on its own clock and watches a full flag. A consumer pops words on a second clock and watches an empty flag. The storage is a small power-of-two array. It is written in the producer's domain and read combinationally in the consumer's domain, so the oldest unread word is always present on the read data port.

Each side keeps a binary pointer with one more bit than the address. The storage address comes from this pointer, and the pointer is also kept in a registered Gray copy. Only the Gray copy crosses to the other domain, through a two-stage synchronizer. The local flag is then formed from the local pointer's next value and the synchronized remote copy. A flag therefore rises on the same edge that fills or drains the last slot. It falls only once the remote pointer has made its way across, so the flags are conservative but never wrong.

Top module: `gray_xfer_fifo`

## Requirements
- R1: While either reset is held, and directly after both are released, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rd_data` shows the oldest unread word, and a cycle with `rd_en` high removes it.
- R3: When a write is accepted that leaves 2^ADDR_W unread words, `full` is 1 directly after that `wr_clk` edge. With fewer unread words and no read in flight, `full` is 0.
- R4: When a read is accepted that removes the last unread word, `empty` is 1 directly after that `rd_clk` edge.
- R5: A write attempted while `full` is 1 is dropped. The stored words, their order and the count of unread words stay unchanged.
- R6: A read attempted while `empty` is 1 has no effect. The next word written is the next word presented on `rd_data`.
- R7: After a write into an empty FIFO, `empty` falls no later than the fourth `rd_clk` edge. After a read from a full FIFO, `full` falls no later than the fourth `wr_clk` edge.
- R8: Each pointer copy that crosses domains changes in at most one bit between consecutive edges of its own clock.
- R9: The occupancy seen from the write side, taken as the write pointer minus the synchronized read pointer, never exceeds 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| full | output | 1 | No free slot; pushes are dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain reset, active low |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest unread word |
| empty | output | 1 | Nothing to read; pops are ignored |

## Verification
A corrupted pointer or a wrong Gray conversion shows up at `rd_data` on the next pop. The word presented is out of order, is a duplicate, or was never written, and this is visible within one read cycle of the flag falling. A flag comparison that is wrong either leaves `full` or `empty` low on the very edge that fills or drains the last slot, or keeps it high more than four cycles after the other side has moved. The sweep over every fill level, and the interleaved stream of unequal clocks, expose both kinds of fault within a few cycles.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int CODE_W = 16;

  function automatic logic [CODE_W-1:0] to_gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] from_gray(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    for (int i = 0; i < CODE_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync2.sv
module afifo_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              full,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);
  import afifo_pkg::*;
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin, wbin_nx, wgray_nx, full_match;
  logic          full_nx;

  assign wr_fire    = wr_en & ~full;
  assign wbin_nx    = wbin + PW'(wr_fire);
  assign wgray_nx   = PW'(to_gray(CODE_W'(wbin_nx)));
  assign full_match = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
  assign full_nx    = (wgray_nx == full_match);
  assign waddr      = wbin[ADDR_W-1:0];

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= full_nx;
    end
  end

  logic [PW-1:0] wr_occ;
  assign wr_occ = wbin - PW'(from_gray(CODE_W'(rgray_sync)));

  // R5
  wr_hold_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |=> $stable(wgray));
  // R8
  wgray_one_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R9
  wr_occ_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= PW'(DEPTH));
  // R3
  full_at_depth_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_occ == PW'(DEPTH)) |-> full);
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl #(
  parameter int ADDR_W = 3
) (
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic              empty,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray
);
  import afifo_pkg::*;
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] rbin, rbin_nx, rgray_nx;
  logic          rd_fire, empty_nx;

  assign rd_fire  = rd_en & ~empty;
  assign rbin_nx  = rbin + PW'(rd_fire);
  assign rgray_nx = PW'(to_gray(CODE_W'(rbin_nx)));
  assign empty_nx = (rgray_nx == wgray_sync);
  assign raddr    = rbin[ADDR_W-1:0];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= empty_nx;
    end
  end

  logic [PW-1:0] rd_occ;
  assign rd_occ = PW'(from_gray(CODE_W'(wgray_sync))) - rbin;

  // R6
  rd_hold_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |=> $stable(rgray));
  // R8
  rgray_one_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R4
  empty_at_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_occ == '0) |-> empty);
  // R9
  rd_occ_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_occ <= PW'(DEPTH));
endmodule

// File: rtl/gray_xfer_fifo.sv
module gray_xfer_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_in_rd, rgray_in_wr;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire;

  afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
    .rgray_sync(rgray_in_wr), .full(full), .wr_fire(wr_fire),
    .waddr(waddr), .wgray(wgray));

  afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .wgray_sync(wgray_in_rd), .empty(empty),
    .raddr(raddr), .rgray(rgray));

  afifo_sync2 #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_rd));

  afifo_sync2 #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_wr));

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data));

  // R1
  wr_reset_state_chk: assert property (@(posedge wr_clk)
    !wr_rst_n |=> !full);
  // R1
  rd_reset_state_chk: assert property (@(posedge rd_clk)
    !rd_rst_n |=> empty);
endmodule

// File: tb/tb_gray_xfer_fifo.sv
module tb_gray_xfer_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic full, empty;

  int compared = 0, mismatched = 0;
  logic [DATA_W-1:0] q[$];
  bit finished = 0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  gray_xfer_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] d, output bit acc);
    @(negedge wr_clk);
    acc = !full;
    wr_en = 1; wr_data = d;
    @(posedge wr_clk); #1;
    wr_en = 0;
    if (acc) q.push_back(d);
  endtask

  task automatic pop(input string req, output bit acc);
    @(negedge rd_clk);
    acc = !empty;
    if (acc) begin
      chk(q.size() > 0, req, "pop with model empty", q.size(), 1);
      if (q.size() > 0) begin
        chk(rd_data == q[0], req, "rd_data order", rd_data, q[0]);
        void'(q.pop_front());
      end
    end
    rd_en = 1;
    @(posedge rd_clk); #1;
    rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit acc;
    // R1: flags during reset and right after release
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(empty == 1, "R1", "empty in reset", empty, 1);
    chk(full == 0, "R1", "full in reset", full, 0);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge rd_clk);
    chk(empty == 1, "R1", "empty after reset", empty, 1);
    chk(full == 0, "R1", "full after reset", full, 0);

    // R6: reads while empty are ignored
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(posedge rd_clk);
    #1 rd_en = 0;
    push(8'h5A, acc);
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty == 0, "R7", "empty falls within 4 rd edges", empty, 0);
    chk(rd_data == 8'h5A, "R6", "first word after empty reads", rd_data, 8'h5A);
    pop("R2", acc);
    @(negedge rd_clk);
    chk(empty == 1, "R4", "empty on last pop", empty, 1);
    settle();

    // R3/R9: sweep every fill level, wrapping pointers repeatedly
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) begin
        push(DATA_W'(k * 16 + i), acc);
        chk(acc == 1, "R9", "write accepted below depth", acc, 1);
        @(negedge wr_clk);
        chk(full == (q.size() == DEPTH), "R3", "full after write", full, q.size() == DEPTH);
      end
      settle();
      chk(empty == 0, "R7", "empty settled low", empty, 0);
      chk(full == (k == DEPTH), "R3", "full settled", full, k == DEPTH);
      if (k == DEPTH) begin
        // R5: drop a write while full
        push(8'hEE, acc);
        chk(acc == 0, "R5", "write while full refused", acc, 0);
        chk(q.size() == DEPTH, "R5", "model count", q.size(), DEPTH);
        pop("R2", acc);
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        chk(full == 0, "R7", "full falls within 4 wr edges", full, 0);
      end
      while (q.size() > 0) pop("R2", acc);
      @(negedge rd_clk);
      chk(empty == 1, "R4", "empty on drain", empty, 1);
      settle();
      chk(empty == 1, "R5", "no stray word after drain", empty, 1);
    end

    // R2: interleaved traffic on unequal clocks
    fork
      begin
        int sent = 0;
        logic [7:0] lf = 8'h1D;
        while (sent < 300) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          if (lf[0] | lf[2]) begin
            push(DATA_W'(sent), acc);
            if (acc) sent++;
          end else @(negedge wr_clk);
        end
      end
      begin
        int got = 0;
        logic [7:0] lr = 8'hA7;
        while (got < 300) begin
          lr = {lr[6:0], lr[7] ^ lr[5] ^ lr[4] ^ lr[3]};
          if (lr[1]) begin
            pop("R2", acc);
            if (acc) got++;
          end else @(negedge rd_clk);
        end
      end
    join
    @(negedge rd_clk);
    chk(empty == 1, "R4", "empty after stream", empty, 1);
    chk(q.size() == 0, "R2", "model drained", q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule